// File: doc/BRIEF.md
# Display Serial Host Interrupt Status Controller

This block gathers one-cycle event pulses from a display serial host engine into a sticky status word. An enable word masks which events may raise the interrupt line. The interrupt line is active low and level sensitive, and it stays low for as long as any enabled status bit remains set. Software clears flags with masked writes of zero. Bits outside the write mask, and bits written with one, are left as they were.

The status word also carries an engine busy flag. This flag is read-only. It is high while the engine reports a command in progress, and while a read response is waiting to be acknowledged. A write of one to the acknowledge bit releases the waiting response: the block emits a one-cycle release strobe to the engine and the busy flag drops. Software typically polls the busy flag until it reads zero, and only then clears the event flags.

Register access uses a write port with a byte-agnostic bit mask and a separate combinational read port. The register addresses are parameters. With the defaults, the enable word is at address 0, the status word at address 1 and the acknowledge word at address 2.

Top module: `dsh_irq_status`

## Requirements
- R1: After reset the enable and status words read 0, `irq_n` is 1, `busy` is 0 and `rx_release` is 0.
- R2: A pulse on `evt_pulse[i]` sets status bit i from the next clock edge on, and the bit stays set until it is cleared. The bit meanings are: 0 read data ready, 1 command done, 2 tearing-effect ready, 3 video-mode done, 4 external tearing-effect ready.
- R3: A write to address 0 updates only the enable bits whose `wr_mask` bit is 1. Enable bits use the same positions as status bits 0 to 4. Enable bits 31 to 5 always read 0.
- R4: A write to address 1 clears each status bit whose mask bit is 1 and whose data bit is 0. Status bits outside the mask are unchanged, and writing 1 never sets a status bit.
- R5: When an event pulse and a clear of the same bit occur in the same cycle, the bit stays set.
- R6: `irq_n` is 0 exactly when some status bit and its enable bit are both 1. Status bits whose enable bit is 0 never pull it low.
- R7: Status bit 31 reads as the busy flag. A high `cmd_active` makes `busy` 1 from the next edge, and busy follows `cmd_active` with one cycle of delay.
- R8: A `rx_arrive` pulse holds `busy` high until a write to address 2 with data bit 0 and mask bit 0 both 1. After that write, `busy` is 0 and `rx_release` is 1 for one cycle. A write to address 2 with data bit 0 or mask bit 0 at 0 has no effect, and an acknowledge with nothing waiting produces no release.
- R9: The busy bit is read-only: a masked write of 0 to status bit 31 leaves `busy` unchanged.
- R10: Address 2 reads as 0, and a write to an unmapped address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | 5 | One-cycle event pulses from the engine |
| cmd_active | input | 1 | Engine is executing a command (level) |
| rx_arrive | input | 1 | One-cycle pulse: a read response is waiting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Write data |
| wr_mask | input | 32 | Write bit mask, 1 = bit takes part |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Read data for `rd_addr` |
| irq_n | output | 1 | Level interrupt, active low |
| busy | output | 1 | Engine busy flag |
| rx_release | output | 1 | One-cycle strobe letting the waiting receive complete |

## Verification
The bench drives an event pulse and a clear of the same bit in one cycle. A design that lets the clear win would lose that event. It writes all-ones data under a partial mask to both the enable and status words. A design that ignores the mask would change neighbouring enable bits, and one that treats a written 1 as a set would raise flags that no event caused. It also sets flags whose enable bit is 0 and checks that the interrupt stays high. Finally, it covers the acknowledge path: writes with only the data bit or only the mask bit set, an acknowledge with nothing waiting, and an attempt to clear busy through the status word. Any of these would cause a wrong design to drop busy or emit a spurious release.

// File: rtl/dsh_irq_pkg.sv
package dsh_irq_pkg;
   // Event bit positions (shared by status and enable words)
   localparam int unsigned EV_RD_READY = 0;
   localparam int unsigned EV_CMD_DONE = 1;
   localparam int unsigned EV_TE_READY = 2;
   localparam int unsigned EV_VM_DONE  = 3;
   localparam int unsigned EV_EXT_TE   = 4;
   localparam int unsigned EV_COUNT    = 5;

   localparam int unsigned WORD_W      = 32;
   localparam int unsigned BUSY_BIT    = 31;
   localparam int unsigned ACK_BIT     = 0;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_EN   = 2'd1,
      SEL_STA  = 2'd2,
      SEL_ACK  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/dsh_irq_decode.sv
module dsh_irq_decode
   import dsh_irq_pkg::*;
#(
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned ADDR_EN  = 0,
   parameter int unsigned ADDR_STA = 1,
   parameter int unsigned ADDR_ACK = 2
) (
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              ack_dat,
   input  logic              ack_msk,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              en_we,
   output logic              sta_we,
   output logic              ack_hit,
   output reg_sel_e          rd_sel
);
   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(ADDR_EN);
   localparam logic [ADDR_W-1:0] A_STA = ADDR_W'(ADDR_STA);
   localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(ADDR_ACK);

   if (ADDR_EN == ADDR_STA || ADDR_EN == ADDR_ACK || ADDR_STA == ADDR_ACK) begin : g_bad_map
      $error("register addresses must be distinct");
   end
   if (ADDR_ACK >= (1 << ADDR_W)) begin : g_bad_addr
      $error("register address does not fit ADDR_W");
   end

   always_comb begin
      en_we   = wr_en && (wr_addr == A_EN);
      sta_we  = wr_en && (wr_addr == A_STA);
      ack_hit = wr_en && (wr_addr == A_ACK) && ack_dat && ack_msk;
   end

   always_comb begin
      if (rd_addr == A_EN)       rd_sel = SEL_EN;
      else if (rd_addr == A_STA) rd_sel = SEL_STA;
      else if (rd_addr == A_ACK) rd_sel = SEL_ACK;
      else                       rd_sel = SEL_NONE;
   end
endmodule

// File: rtl/dsh_irq_bank.sv
module dsh_irq_bank #(
   parameter int unsigned N_EVT = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt,
   input  logic             en_we,
   input  logic             sta_we,
   input  logic [N_EVT-1:0] wdat,
   input  logic [N_EVT-1:0] wmsk,
   output logic [N_EVT-1:0] en_q,
   output logic [N_EVT-1:0] sta_q
);
   if (N_EVT == 0) begin : g_bad_cnt
      $error("N_EVT must be at least 1");
   end

   for (genvar i = 0; i < N_EVT; i++) begin : g_bit
      logic clr;
      assign clr = sta_we && wmsk[i] && !wdat[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sta_q[i] <= 1'b0;
            en_q[i]  <= 1'b0;
         end else begin
            // event wins over a clear in the same cycle
            sta_q[i] <= evt[i] | (sta_q[i] & ~clr);
            if (en_we && wmsk[i]) en_q[i] <= wdat[i];
         end
      end

      p_evt_sets_r2 : assert property (@(posedge clk) disable iff (!rst_n)
         evt[i] |=> sta_q[i]);

      p_no_self_set_r4 : assert property (@(posedge clk) disable iff (!rst_n)
         $rose(sta_q[i]) |-> $past(evt[i]));

      p_clear_takes_r4 : assert property (@(posedge clk) disable iff (!rst_n)
         (sta_we && wmsk[i] && !wdat[i] && !evt[i]) |=> !sta_q[i]);

      p_prio_evt_r5 : assert property (@(posedge clk) disable iff (!rst_n)
         (sta_we && wmsk[i] && !wdat[i] && evt[i]) |=> sta_q[i]);

      p_en_masked_r3 : assert property (@(posedge clk) disable iff (!rst_n)
         !(en_we && wmsk[i]) |=> $stable(en_q[i]));
   end
endmodule

// File: rtl/dsh_irq_busy.sv
module dsh_irq_busy (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_active,
   input  logic rx_arrive,
   input  logic ack_hit,
   output logic busy,
   output logic rx_release
);
   logic cmd_q;
   logic rx_wait;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q      <= 1'b0;
         rx_wait    <= 1'b0;
         rx_release <= 1'b0;
      end else begin
         cmd_q      <= cmd_active;
         rx_wait    <= rx_arrive | (rx_wait & ~ack_hit);
         rx_release <= ack_hit & rx_wait;
      end
   end

   assign busy = cmd_q | rx_wait;

   p_cmd_busy_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_active |=> busy);

   p_wait_holds_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_wait && !ack_hit) |=> busy);

   p_ack_frees_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_wait && ack_hit && !rx_arrive && !cmd_active) |=> (rx_release && !busy));

   p_no_idle_rel_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_wait) |=> !rx_release);
endmodule

// File: rtl/dsh_irq_status.sv
module dsh_irq_status
   import dsh_irq_pkg::*;
#(
   parameter int unsigned N_EVT    = EV_COUNT,
   parameter int unsigned DATA_W   = WORD_W,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned BUSY_POS = BUSY_BIT,
   parameter int unsigned ADDR_EN  = 0,
   parameter int unsigned ADDR_STA = 1,
   parameter int unsigned ADDR_ACK = 2,
   parameter bit          IRQ_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EVT-1:0]  evt_pulse,
   input  logic              cmd_active,
   input  logic              rx_arrive,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] wr_mask,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq_n,
   output logic              busy,
   output logic              rx_release
);
   localparam int unsigned PAD_W = DATA_W - N_EVT;

   if (N_EVT >= BUSY_POS) begin : g_bad_evt
      $error("event bits overlap the busy bit");
   end
   if (BUSY_POS >= DATA_W) begin : g_bad_busy
      $error("busy bit outside the data word");
   end

   logic       en_we, sta_we, ack_hit;
   reg_sel_e   rd_sel;
   logic [N_EVT-1:0] en_q, sta_q;
   logic       unused_wbits;

   assign unused_wbits = ^{wr_data, wr_mask};

   dsh_irq_decode #(
      .ADDR_W  (ADDR_W),
      .ADDR_EN (ADDR_EN),
      .ADDR_STA(ADDR_STA),
      .ADDR_ACK(ADDR_ACK)
   ) i_decode (
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .ack_dat(wr_data[ACK_BIT]),
      .ack_msk(wr_mask[ACK_BIT]),
      .rd_addr(rd_addr),
      .en_we  (en_we),
      .sta_we (sta_we),
      .ack_hit(ack_hit),
      .rd_sel (rd_sel)
   );

   dsh_irq_bank #(.N_EVT(N_EVT)) i_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .evt   (evt_pulse),
      .en_we (en_we),
      .sta_we(sta_we),
      .wdat  (wr_data[N_EVT-1:0]),
      .wmsk  (wr_mask[N_EVT-1:0]),
      .en_q  (en_q),
      .sta_q (sta_q)
   );

   dsh_irq_busy i_busy (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_active(cmd_active),
      .rx_arrive (rx_arrive),
      .ack_hit   (ack_hit),
      .busy      (busy),
      .rx_release(rx_release)
   );

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_EN:  rd_data = {{PAD_W{1'b0}}, en_q};
         SEL_STA: begin
            rd_data = {{PAD_W{1'b0}}, sta_q};
            rd_data[BUSY_POS] = busy;
         end
         default: rd_data = '0;
      endcase
   end

   if (IRQ_REG) begin : g_irq_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_n <= 1'b1;
         else        irq_n <= ~|(sta_q & en_q);
      end
      p_irq_follow_r6 : assert property (@(posedge clk) disable iff (!rst_n)
         (sta_q == '0) |=> irq_n);
   end else begin : g_irq_comb
      assign irq_n = ~|(sta_q & en_q);
      p_irq_idle_r6 : assert property (@(posedge clk) disable iff (!rst_n)
         (en_q == '0) |-> irq_n);
   end

   p_busy_bit_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(ADDR_STA)) |-> (rd_data[BUSY_POS] == busy));

   p_ack_reads_zero_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == ADDR_W'(ADDR_ACK)) |-> (rd_data == '0));
endmodule

// File: tb/test_dsh_irq_status.sv
module test_dsh_irq_status;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  evt_pulse = '0;
   logic        cmd_active = 1'b0;
   logic        rx_arrive = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] wr_mask = '0;
   logic [3:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq_n, busy, rx_release;

   int errors = 0;
   int checks = 0;

   typedef struct packed {
      logic [3:0]  sel;
      logic [31:0] data;
      logic        irq_n;
      logic        busy;
      logic        rel;
      logic [7:0]  req;
   } sb_item_t;

   sb_item_t sb_q[$];

   always #10 clk = ~clk;   // 50 MHz

   dsh_irq_status i_dsh_irq_status (
      .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .cmd_active(cmd_active),
      .rx_arrive(rx_arrive), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_mask(wr_mask), .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n),
      .busy(busy), .rx_release(rx_release)
   );

   // one clock of stimulus; pulses drop after the edge
   task automatic step(input logic [4:0] ev, input logic rx, input logic we,
                       input logic [3:0] a, input logic [31:0] d, input logic [31:0] m);
      @(negedge clk);
      evt_pulse = ev; rx_arrive = rx; wr_en = we; wr_addr = a; wr_data = d; wr_mask = m;
      @(posedge clk);
      #1;
      evt_pulse = '0; rx_arrive = 1'b0; wr_en = 1'b0;
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic [31:0] m);
      step(5'b0, 1'b0, 1'b1, a, d, m);
   endtask

   task automatic ev(input logic [4:0] e);
      step(e, 1'b0, 1'b0, 4'd0, 32'd0, 32'd0);
   endtask

   // driver side of the scoreboard
   task automatic expect_state(input logic [3:0] sel, input logic [31:0] data,
                               input logic ein, input logic eb, input logic er,
                               input logic [7:0] req);
      sb_item_t it;
      it = '{sel: sel, data: data, irq_n: ein, busy: eb, rel: er, req: req};
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   // monitor: pops expected items and compares against the outputs
   initial begin
      forever begin
         sb_item_t it;
         wait (sb_q.size() != 0);
         it = sb_q[0];
         rd_addr = it.sel;
         #2;
         checks += 4;
         if (rd_data !== it.data) begin
            errors++;
            $display("FAIL R%0d rd_data[%0d] actual=%h expected=%h", it.req, it.sel, rd_data, it.data);
         end
         if (irq_n !== it.irq_n) begin
            errors++;
            $display("FAIL R%0d irq_n actual=%b expected=%b", it.req, irq_n, it.irq_n);
         end
         if (busy !== it.busy) begin
            errors++;
            $display("FAIL R%0d busy actual=%b expected=%b", it.req, busy, it.busy);
         end
         if (rx_release !== it.rel) begin
            errors++;
            $display("FAIL R%0d rx_release actual=%b expected=%b", it.req, rx_release, it.rel);
         end
         sb_q.delete(0);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      expect_state(4'd1, 32'h0, 1'b1, 1'b0, 1'b0, 8'd1);  // R1 status
      expect_state(4'd0, 32'h0, 1'b1, 1'b0, 1'b0, 8'd1);  // R1 enable
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      expect_state(4'd1, 32'h0, 1'b1, 1'b0, 1'b0, 8'd1);  // R1 after release

      ev(5'b00010);                                       // command done
      expect_state(4'd1, 32'h2, 1'b1, 1'b0, 1'b0, 8'd2);  // R2 set, R6 disabled
      @(posedge clk); #1;
      expect_state(4'd1, 32'h2, 1'b1, 1'b0, 1'b0, 8'd2);  // R2 sticky

      wr(4'd0, 32'h1F, 32'h0A);
      expect_state(4'd0, 32'h0A, 1'b0, 1'b0, 1'b0, 8'd3); // R3 mask, R6 asserted
      wr(4'd0, 32'hFFFF_FFFF, 32'hFFFF_FFF0);
      expect_state(4'd0, 32'h1A, 1'b0, 1'b0, 1'b0, 8'd3); // R3 upper bits read 0

      wr(4'd1, 32'h0, 32'h1);
      expect_state(4'd1, 32'h2, 1'b0, 1'b0, 1'b0, 8'd4);  // R4 outside mask kept
      wr(4'd1, 32'hFFFF, 32'hFFFF);
      expect_state(4'd1, 32'h2, 1'b0, 1'b0, 1'b0, 8'd4);  // R4 writing 1 sets nothing
      wr(4'd1, 32'h0, 32'h2);
      expect_state(4'd1, 32'h0, 1'b1, 1'b0, 1'b0, 8'd4);  // R4 clear, R6 released

      ev(5'b00101);
      expect_state(4'd1, 32'h5, 1'b1, 1'b0, 1'b0, 8'd6);  // R6 disabled bits quiet
      ev(5'b10000);
      expect_state(4'd1, 32'h15, 1'b0, 1'b0, 1'b0, 8'd6); // R6 enabled bit 4

      step(5'b01000, 1'b0, 1'b1, 4'd1, 32'h0, 32'h18);
      expect_state(4'd1, 32'h0D, 1'b0, 1'b0, 1'b0, 8'd5); // R5 event beats clear
      wr(4'd1, 32'h0, 32'hFF);
      expect_state(4'd1, 32'h0, 1'b1, 1'b0, 1'b0, 8'd4);  // R4 full clear

      @(negedge clk); cmd_active = 1'b1;
      @(posedge clk); #1;
      expect_state(4'd1, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 8'd7); // R7 busy bit 31
      wr(4'd1, 32'h0, 32'h8000_0000);
      expect_state(4'd1, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 8'd9); // R9 read-only
      @(negedge clk); cmd_active = 1'b0;
      @(posedge clk); #1;
      expect_state(4'd1, 32'h0, 1'b1, 1'b0, 1'b0, 8'd7);  // R7 busy follows

      step(5'b0, 1'b1, 1'b0, 4'd0, 32'h0, 32'h0);
      expect_state(4'd1, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 8'd8); // R8 waiting
      wr(4'd2, 32'h0, 32'h1);
      expect_state(4'd1, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 8'd8); // R8 data 0 ignored
      wr(4'd2, 32'h1, 32'h0);
      expect_state(4'd1, 32'h8000_0000, 1'b1, 1'b1, 1'b0, 8'd8); // R8 mask 0 ignored
      wr(4'd2, 32'h1, 32'h1);
      expect_state(4'd1, 32'h0, 1'b1, 1'b0, 1'b1, 8'd8);  // R8 release strobe
      @(posedge clk); #1;
      expect_state(4'd2, 32'h0, 1'b1, 1'b0, 1'b0, 8'd10); // R10 ack reads 0, R8 one cycle

      wr(4'd2, 32'h1, 32'h1);
      expect_state(4'd1, 32'h0, 1'b1, 1'b0, 1'b0, 8'd8);  // R8 no idle release

      wr(4'd5, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      expect_state(4'd0, 32'h1A, 1'b1, 1'b0, 1'b0, 8'd10); // R10 unmapped write
      expect_state(4'd1, 32'h0, 1'b1, 1'b0, 1'b0, 8'd10);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule